// File: doc/BRIEF.md
# Dual-Channel Serial Register and Interrupt Core

This block is the host-facing register layer of a two-channel serial controller. The host uses a byte-wide synchronous port. Each channel has a control port and a data port. The control port reaches sixteen write registers and sixteen read registers indirectly, through a pointer that clears itself after use. The data port carries received bytes out to the host and takes transmit bytes in.

The block keeps the receive and transmit interrupt state for each channel. That state is a pending flag and an under-service flag for each direction. Receive service takes precedence over transmit service. From this state the block builds a shared interrupt vector, a pending-summary byte and one combined interrupt request. Received bytes and line-break events arrive on simple strobes. Control writes can reset either channel or both.

Top module: `duo_serial_intc`

## Requirements
- R1: After reset, a channel's status byte reads 0x44 and its special-status byte (read register 1) reads 0x07. The vector (read register 2 of channel B) reads 0x06, the pending byte (read register 3 of channel A) reads 0x00, irq is low and the break interrupt enable (write register 15 bit 7) is set.
- R2: A control write while the pointer is zero loads the pointer from bits 2:0. A command field of 001 in bits 5:3 adds 8 to the pointer. Any control access while the pointer is nonzero targets that register and then returns the pointer to zero. A control read at pointer zero returns the status byte.
- R3: host_addr[0] selects control (0) or data (1), and host_addr[1] selects channel A (0) or B (1). Read data appears on host_rdata one cycle after the read and holds until the next read.
- R4: A received byte is accepted only when receive is enabled (write register 3 bit 0) and receive-available (status bit 0) is clear. Acceptance stores the byte, sets status bit 0 and raises the receive interrupt. Otherwise rx_reject is high in that cycle and the byte is dropped.
- R5: A data read returns the stored byte, clears status bit 0 and clears the receive interrupt.
- R6: A data write raises the transmit interrupt. Control command 101 (byte 0x28 at pointer zero) clears it.
- R7: A transmit interrupt becomes under service only while no receive interrupt of the same channel is under service. Clearing the receive interrupt re-raises a transmit interrupt that is still pending, and clearing the transmit interrupt re-raises a receive interrupt that is still pending.
- R8: Command 111 (byte 0x38) clears receive under-service and then places a pending transmit interrupt under service. If no receive interrupt is under service, it clears transmit under-service instead.
- R9: The vector reports the highest under-service source, in the order A receive, A transmit, B receive, B transmit. The codes are A receive 0x0C, A transmit 0x08, B receive 0x04, B transmit 0x00 and none 0x06. When the reporting channel's status-high bit (write register 9 bit 4) is set, the codes are 0x30, 0x10, 0x20, 0x00 and 0x60. "None" uses channel B's bit.
- R10: The pending byte has bit 5 for A receive, bit 4 for A transmit, bit 3 for A external, bit 2 for B receive, bit 1 for B transmit and bit 0 for B external. A transmit bit shows only when transmit interrupts are enabled (write register 1 bit 1). An external bit shows a break that is enabled.
- R11: irq is the OR over both channels of three terms: transmit enabled and pending, receive mode (write register 1 bits 4:3) 01 or 10 with receive pending, and break enabled with break status set.
- R12: A break strobe sets status bit 7. Clearing write register 15 bit 7 masks it from irq.
- R13: Writing register 9 with bits 7:6 = 01 resets channel B, 10 resets channel A and 11 resets both, from either channel's control port. A write with bits 7:6 = 00 stores the status-high bit.
- R14: Write registers 12 and 13 read back unchanged through read registers 12 and 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Bit 0: control/data, bit 1: channel A/B |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, one cycle after the read |
| rx_valid | input | 2 | Received-byte strobe per channel (bit 0 = A) |
| rx_data | input | 16 | Received byte per channel (low byte = A) |
| brk_evt | input | 2 | Line-break strobe per channel |
| rx_reject | output | 2 | Received byte dropped this cycle |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: two channels and byte-wide registers. That is the only configuration for which the vector and pending codes are defined. With it, the bench reaches the cross-channel cases: a reset command issued from one channel's port that lands on the other channel, and the vector priority when both channels have an interrupt under service. It also reaches the ordering cases between receive and transmit service within one channel, with the receive interrupt raised before and after the transmit interrupt.

// File: rtl/duo_serial_pkg.sv
package duo_serial_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_CH  = 2;
  localparam int PTR_W   = 4;
  localparam int CMD_W   = 3;
  localparam int SEL_W   = $clog2(NUM_CH);

  // command field values (control byte bits 5:3 at pointer zero)
  localparam logic [CMD_W-1:0] CMD_POINT_HI = 3'b001;
  localparam logic [CMD_W-1:0] CMD_CLR_TX   = 3'b101;
  localparam logic [CMD_W-1:0] CMD_RST_IUS  = 3'b111;

  // register indices the block decodes
  localparam logic [PTR_W-1:0] REG_STATUS  = 4'd0;
  localparam logic [PTR_W-1:0] REG_INT_CFG = 4'd1;
  localparam logic [PTR_W-1:0] REG_VECTOR  = 4'd2;
  localparam logic [PTR_W-1:0] REG_RX_CFG  = 4'd3;
  localparam logic [PTR_W-1:0] REG_MASTER  = 4'd9;
  localparam logic [PTR_W-1:0] REG_DIV_LO  = 4'd12;
  localparam logic [PTR_W-1:0] REG_DIV_HI  = 4'd13;
  localparam logic [PTR_W-1:0] REG_EXT_CFG = 4'd15;

  localparam logic [DATA_W-1:0] SPECIAL_IDLE = 8'h07;

  // vector codes
  localparam logic [DATA_W-1:0] VEC_A_RX_LO = 8'h0C;
  localparam logic [DATA_W-1:0] VEC_A_RX_HI = 8'h30;
  localparam logic [DATA_W-1:0] VEC_A_TX_LO = 8'h08;
  localparam logic [DATA_W-1:0] VEC_A_TX_HI = 8'h10;
  localparam logic [DATA_W-1:0] VEC_B_RX_LO = 8'h04;
  localparam logic [DATA_W-1:0] VEC_B_RX_HI = 8'h20;
  localparam logic [DATA_W-1:0] VEC_B_TX    = 8'h00;
  localparam logic [DATA_W-1:0] VEC_NONE_LO = 8'h06;
  localparam logic [DATA_W-1:0] VEC_NONE_HI = 8'h60;

  typedef struct packed {
    logic [PTR_W-1:0]  ptr;
    logic              tx_ie;
    logic [1:0]        rx_mode;
    logic              rx_en;
    logic              stat_hi;
    logic              brk_ie;
    logic [DATA_W-1:0] div_lo;
    logic [DATA_W-1:0] div_hi;
    logic [DATA_W-1:0] rx_buf;
    logic              rxav;
    logic              brk;
    logic              rx_int;
    logic              tx_int;
    logic              rx_us;
    logic              tx_us;
  } chan_st_t;

  localparam chan_st_t CHAN_RST = '{
    ptr: '0, tx_ie: 1'b0, rx_mode: 2'b00, rx_en: 1'b0, stat_hi: 1'b0,
    brk_ie: 1'b1, div_lo: '0, div_hi: '0, rx_buf: '0, rxav: 1'b0,
    brk: 1'b0, rx_int: 1'b0, tx_int: 1'b0, rx_us: 1'b0, tx_us: 1'b0};
endpackage

// File: rtl/duo_serial_rstsync.sv
module duo_serial_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/duo_serial_chan.sv
module duo_serial_chan
  import duo_serial_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              wr_en,
  input  logic              data_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              soft_rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              brk_evt,
  output logic [PTR_W-1:0]  ptr,
  output logic              rx_reject,
  output logic              irq_req,
  output logic              rx_pend,
  output logic              tx_pend,
  output logic              ext_pend,
  output logic              rx_us,
  output logic              tx_us,
  output logic              stat_hi,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] rx_buf,
  output logic [DATA_W-1:0] div_lo,
  output logic [DATA_W-1:0] div_hi,
  output logic [1:0]        rst_cmd
);
  chan_st_t st_q, st_d;
  logic     st_en;
  logic     rx_take;

  assign rx_take = rx_valid & st_q.rx_en & ~st_q.rxav;
  assign st_en   = acc | rx_valid | brk_evt | soft_rst;

  always_comb begin
    st_d    = st_q;
    rst_cmd = 2'b00;
    if (acc && !data_sel && wr_en) begin
      if (st_q.ptr == '0) begin
        st_d.ptr = {(wdata[5:3] == CMD_POINT_HI), wdata[2:0]};
        if (wdata[5:3] == CMD_CLR_TX) begin
          st_d.tx_int = 1'b0;
          st_d.tx_us  = 1'b0;
          if (st_d.rx_int) st_d.rx_us = 1'b1;
        end else if (wdata[5:3] == CMD_RST_IUS) begin
          if (st_d.rx_us) begin
            st_d.rx_us = 1'b0;
            if (st_d.tx_int) st_d.tx_us = 1'b1;
          end else begin
            st_d.tx_us = 1'b0;
          end
        end
      end else begin
        st_d.ptr = '0;
        case (st_q.ptr)
          REG_INT_CFG: begin
            st_d.tx_ie   = wdata[1];
            st_d.rx_mode = wdata[4:3];
          end
          REG_RX_CFG:  st_d.rx_en = wdata[0];
          REG_MASTER: begin
            rst_cmd = wdata[7:6];
            if (wdata[7:6] == 2'b00) st_d.stat_hi = wdata[4];
          end
          REG_DIV_LO:  st_d.div_lo = wdata;
          REG_DIV_HI:  st_d.div_hi = wdata;
          REG_EXT_CFG: st_d.brk_ie = wdata[7];
          default: ;
        endcase
      end
    end else if (acc && !data_sel) begin
      st_d.ptr = '0;
    end else if (acc && wr_en) begin
      st_d.tx_int = 1'b1;
      if (!st_d.rx_us) st_d.tx_us = 1'b1;
    end else if (acc) begin
      st_d.rxav   = 1'b0;
      st_d.rx_int = 1'b0;
      st_d.rx_us  = 1'b0;
      if (st_d.tx_int) st_d.tx_us = 1'b1;
    end
    if (rx_take) begin
      st_d.rxav   = 1'b1;
      st_d.rx_buf = rx_data;
      st_d.rx_int = 1'b1;
      st_d.rx_us  = 1'b1;
    end
    if (brk_evt) st_d.brk = 1'b1;
    if (soft_rst) st_d = CHAN_RST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= CHAN_RST;
    else if (st_en) st_q <= st_d;
  end

  assign ptr       = st_q.ptr;
  assign rx_reject = rx_valid & ~rx_take;
  assign rx_pend   = st_q.rx_int;
  assign tx_pend   = st_q.tx_ie & st_q.tx_int;
  assign ext_pend  = st_q.brk_ie & st_q.brk;
  assign irq_req   = tx_pend | ext_pend |
                     (((st_q.rx_mode == 2'b01) || (st_q.rx_mode == 2'b10)) & st_q.rx_int);
  assign rx_us     = st_q.rx_us;
  assign tx_us     = st_q.tx_us;
  assign stat_hi   = st_q.stat_hi;
  assign status    = {st_q.brk, 1'b1, 3'b000, 1'b1, 1'b0, st_q.rxav};
  assign rx_buf    = st_q.rx_buf;
  assign div_lo    = st_q.div_lo;
  assign div_hi    = st_q.div_hi;
endmodule

// File: rtl/duo_serial_vec.sv
module duo_serial_vec
  import duo_serial_pkg::*;
(
  input  logic [NUM_CH-1:0] rx_us,
  input  logic [NUM_CH-1:0] tx_us,
  input  logic [NUM_CH-1:0] rx_pend,
  input  logic [NUM_CH-1:0] tx_pend,
  input  logic [NUM_CH-1:0] ext_pend,
  input  logic [NUM_CH-1:0] stat_hi,
  output logic [DATA_W-1:0] vector,
  output logic [DATA_W-1:0] pending
);
  // index 0 is channel A, index 1 is channel B; A outranks B
  always_comb begin
    if (rx_us[0])      vector = stat_hi[0] ? VEC_A_RX_HI : VEC_A_RX_LO;
    else if (tx_us[0]) vector = stat_hi[0] ? VEC_A_TX_HI : VEC_A_TX_LO;
    else if (rx_us[1]) vector = stat_hi[1] ? VEC_B_RX_HI : VEC_B_RX_LO;
    else if (tx_us[1]) vector = VEC_B_TX;
    else               vector = stat_hi[1] ? VEC_NONE_HI : VEC_NONE_LO;
  end

  assign pending = {2'b00, rx_pend[0], tx_pend[0], ext_pend[0],
                    rx_pend[1], tx_pend[1], ext_pend[1]};
endmodule

// File: rtl/duo_serial_intc.sv
module duo_serial_intc
  import duo_serial_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_sel,
  input  logic                          host_we,
  input  logic [SEL_W:0]                host_addr,
  input  logic [DATA_W-1:0]             host_wdata,
  output logic [DATA_W-1:0]             host_rdata,
  input  logic [NUM_CH-1:0]             rx_valid,
  input  logic [NUM_CH-1:0][DATA_W-1:0] rx_data,
  input  logic [NUM_CH-1:0]             brk_evt,
  output logic [NUM_CH-1:0]             rx_reject,
  output logic                          irq
);
  logic                 rst_n_sync;
  logic [PTR_W-1:0]     ptr_w    [NUM_CH];
  logic [DATA_W-1:0]    status_w [NUM_CH];
  logic [DATA_W-1:0]    rxbuf_w  [NUM_CH];
  logic [DATA_W-1:0]    divlo_w  [NUM_CH];
  logic [DATA_W-1:0]    divhi_w  [NUM_CH];
  logic [1:0]           rstcmd_w [NUM_CH];
  logic [NUM_CH-1:0]    irq_w, rxp_w, txp_w, extp_w, rxus_w, txus_w, sthi_w;
  logic [NUM_CH-1:0]    soft_rst;
  logic [DATA_W-1:0]    vec_w, pend_w;
  logic [DATA_W-1:0]    rd_byte;
  logic [DATA_W-1:0]    rdata_q;
  logic                 rd_en;
  logic [SEL_W-1:0]     rd_ch;

  duo_serial_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  // reset command bit 1 targets channel A, bit 0 targets channel B
  assign soft_rst[0] = rstcmd_w[0][1] | rstcmd_w[1][1];
  assign soft_rst[1] = rstcmd_w[0][0] | rstcmd_w[1][0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    duo_serial_chan u_chan (
      .clk(clk), .rst_n(rst_n_sync),
      .acc(host_sel && (host_addr[SEL_W:1] == SEL_W'(c))),
      .wr_en(host_we), .data_sel(host_addr[0]), .wdata(host_wdata),
      .soft_rst(soft_rst[c]),
      .rx_valid(rx_valid[c]), .rx_data(rx_data[c]), .brk_evt(brk_evt[c]),
      .ptr(ptr_w[c]), .rx_reject(rx_reject[c]), .irq_req(irq_w[c]),
      .rx_pend(rxp_w[c]), .tx_pend(txp_w[c]), .ext_pend(extp_w[c]),
      .rx_us(rxus_w[c]), .tx_us(txus_w[c]), .stat_hi(sthi_w[c]),
      .status(status_w[c]), .rx_buf(rxbuf_w[c]),
      .div_lo(divlo_w[c]), .div_hi(divhi_w[c]), .rst_cmd(rstcmd_w[c]));
  end

  duo_serial_vec u_vec (
    .rx_us(rxus_w), .tx_us(txus_w), .rx_pend(rxp_w), .tx_pend(txp_w),
    .ext_pend(extp_w), .stat_hi(sthi_w), .vector(vec_w), .pending(pend_w));

  assign rd_ch = host_addr[SEL_W:1];
  assign rd_en = host_sel & ~host_we;

  always_comb begin
    if (host_addr[0]) begin
      rd_byte = rxbuf_w[rd_ch];
    end else begin
      case (ptr_w[rd_ch])
        REG_STATUS:  rd_byte = status_w[rd_ch];
        REG_INT_CFG: rd_byte = SPECIAL_IDLE;
        REG_VECTOR:  rd_byte = (rd_ch == SEL_W'(1)) ? vec_w : '0;
        REG_RX_CFG:  rd_byte = (rd_ch == SEL_W'(0)) ? pend_w : '0;
        REG_DIV_LO:  rd_byte = divlo_w[rd_ch];
        REG_DIV_HI:  rd_byte = divhi_w[rd_ch];
        default:     rd_byte = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) rdata_q <= '0;
    else if (rd_en)  rdata_q <= rd_byte;
  end

  assign host_rdata = rdata_q;
  assign irq        = |irq_w;
endmodule

// File: rtl/duo_serial_intc_chk.sv
module duo_serial_intc_chk
  import duo_serial_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n_sync,
  input logic                          host_sel,
  input logic                          host_we,
  input logic [SEL_W:0]                host_addr,
  input logic [NUM_CH-1:0]             rx_valid,
  input logic [NUM_CH-1:0]             rx_reject,
  input logic [NUM_CH-1:0]             brk_evt,
  input logic                          irq,
  input logic [DATA_W-1:0]             host_rdata,
  input logic [DATA_W-1:0]             vec_w,
  input logic [DATA_W-1:0]             pend_w
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam int RXB = (c == 0) ? 5 : 2;

    assert_reject_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
      rx_reject[c] |-> rx_valid[c]);

    assert_read_clears_rx_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (host_sel && !host_we && host_addr[0] && (host_addr[SEL_W:1] == SEL_W'(c)) && !rx_valid[c])
      |=> !pend_w[RXB]);
  end

  assert_write_raises_tx_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (host_sel && host_we && host_addr[0]) |=> (vec_w != VEC_NONE_LO) && (vec_w != VEC_NONE_HI));

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(host_sel && !host_we) |=> $stable(host_rdata));

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(irq) |-> $past(host_sel || (|rx_valid) || (|brk_evt)));
endmodule

bind duo_serial_intc duo_serial_intc_chk u_chk (.*);

// File: tb/duo_serial_intc_bench.sv
`timescale 1ns/1ps
module duo_serial_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_sel, host_we;
  logic [1:0]  host_addr;
  logic [7:0]  host_wdata, host_rdata;
  logic [1:0]  rx_valid, brk_evt, rx_reject;
  logic [1:0][7:0] rx_data;
  logic        irq;
  int checks = 0;
  int failures = 0;

  localparam bit CA = 1'b0;
  localparam bit CB = 1'b1;

  always #2 clk = ~clk;

  duo_serial_intc u_duo_serial_intc (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .brk_evt(brk_evt),
    .rx_reject(rx_reject), .irq(irq));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input bit ch, input bit dsel, input logic [7:0] v);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_addr = {ch, dsel}; host_wdata = v;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd(input bit ch, input bit dsel, output logic [7:0] v);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b0; host_addr = {ch, dsel};
    @(negedge clk);
    host_sel = 1'b0;
    v = host_rdata;
  endtask

  function automatic logic [7:0] ptr_byte(input int n);
    return (n < 8) ? 8'(n) : 8'(8'h08 | (n - 8));
  endfunction

  task automatic wr_reg(input bit ch, input int n, input logic [7:0] v);
    wr(ch, 1'b0, ptr_byte(n));
    wr(ch, 1'b0, v);
  endtask

  task automatic rd_reg(input bit ch, input int n, output logic [7:0] v);
    wr(ch, 1'b0, ptr_byte(n));
    rd(ch, 1'b0, v);
  endtask

  task automatic rx_strobe(input bit ch, input logic [7:0] v, output logic rej);
    @(negedge clk);
    rx_valid[ch] = 1'b1; rx_data[ch] = v;
    #1 rej = rx_reject[ch];
    @(negedge clk);
    rx_valid[ch] = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(CA, 1'b0, v);     chk("R1 status A", v, 8'h44);
    rd_reg(CA, 1, v);    chk("R1 special A", v, 8'h07);
    rd_reg(CB, 2, v);    chk("R1 vector", v, 8'h06);
    rd_reg(CA, 3, v);    chk("R1 pending", v, 8'h00);
    rd_reg(CA, 2, v);    chk("R1 reg2 on A", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_pointer;
    logic [7:0] v;
    wr_reg(CA, 12, 8'h5A);
    wr_reg(CA, 13, 8'hC3);
    rd(CA, 1'b0, v);     chk("R2 pointer zero after write", v, 8'h44);
    rd_reg(CA, 12, v);   chk("R14 divisor low", v, 8'h5A);
    rd_reg(CA, 13, v);   chk("R14 divisor high", v, 8'hC3);
    rd_reg(CA, 4, v);    chk("R2 pointer 4 read", v, 8'h00);
    rd(CA, 1'b0, v);     chk("R2 pointer zero after read", v, 8'h44);
    @(negedge clk);
    chk("R3 rdata held", host_rdata, 8'h44);
    rd_reg(CB, 12, v);   chk("R3 channel B separate", v, 8'h00);
  endtask

  task automatic t_receive;
    logic [7:0] v; logic rej;
    wr_reg(CA, 3, 8'h01);
    rx_strobe(CA, 8'h3C, rej); chk("R4 accept", {7'd0, rej}, 8'h00);
    rd(CA, 1'b0, v);     chk("R4 status rxav", v, 8'h45);
    chk("R11 rx mode 00 no irq", {7'd0, irq}, 8'h00);
    rd_reg(CA, 3, v);    chk("R10 A rx pending", v, 8'h20);
    rd_reg(CB, 2, v);    chk("R9 A rx vector", v, 8'h0C);
    rx_strobe(CA, 8'h77, rej); chk("R4 reject full", {7'd0, rej}, 8'h01);
    rd(CA, 1'b1, v);     chk("R5 data byte", v, 8'h3C);
    rd(CA, 1'b0, v);     chk("R5 status cleared", v, 8'h44);
    rd_reg(CB, 2, v);    chk("R5 vector none", v, 8'h06);
    rx_strobe(CB, 8'h12, rej); chk("R4 reject disabled", {7'd0, rej}, 8'h01);
    rd(CB, 1'b0, v);     chk("R4 B status unchanged", v, 8'h44);
  endtask

  task automatic t_irq;
    logic [7:0] v; logic rej;
    wr_reg(CA, 1, 8'h10);
    rx_strobe(CA, 8'h11, rej);
    chk("R11 rx mode 10 irq", {7'd0, irq}, 8'h01);
    rd(CA, 1'b1, v);
    chk("R11 irq after read", {7'd0, irq}, 8'h00);
    wr_reg(CA, 1, 8'h08);
    rx_strobe(CA, 8'h22, rej);
    chk("R11 rx mode 01 irq", {7'd0, irq}, 8'h01);
    rd(CA, 1'b1, v);     chk("R5 second byte", v, 8'h22);
  endtask

  task automatic t_transmit;
    logic [7:0] v;
    wr_reg(CA, 1, 8'h00);
    wr(CA, 1'b1, 8'h99);
    chk("R11 tx disabled no irq", {7'd0, irq}, 8'h00);
    rd_reg(CA, 3, v);    chk("R10 tx bit masked", v, 8'h00);
    rd_reg(CB, 2, v);    chk("R6 A tx vector", v, 8'h08);
    wr_reg(CA, 1, 8'h02);
    chk("R11 tx enabled irq", {7'd0, irq}, 8'h01);
    rd_reg(CA, 3, v);    chk("R10 A tx pending", v, 8'h10);
    wr(CA, 1'b0, 8'h28);
    chk("R6 clear tx irq", {7'd0, irq}, 8'h00);
    rd_reg(CB, 2, v);    chk("R6 vector after clear", v, 8'h06);
  endtask

  task automatic t_service;
    logic [7:0] v; logic rej;
    wr_reg(CA, 1, 8'h12);
    rx_strobe(CA, 8'h21, rej);
    wr(CA, 1'b1, 8'h01);
    rd_reg(CB, 2, v);    chk("R7 rx blocks tx", v, 8'h0C);
    rd_reg(CA, 3, v);    chk("R10 A rx and tx", v, 8'h30);
    rd(CA, 1'b1, v);
    rd_reg(CB, 2, v);    chk("R7 rx clear re-raises tx", v, 8'h08);
    wr(CA, 1'b0, 8'h28);
    rd_reg(CB, 2, v);    chk("R7 all clear", v, 8'h06);
    rx_strobe(CA, 8'h31, rej);
    wr(CA, 1'b0, 8'h38);
    rd_reg(CB, 2, v);    chk("R8 IUS clears rx", v, 8'h06);
    rd_reg(CA, 3, v);    chk("R8 rx still pending", v, 8'h20);
    wr(CA, 1'b1, 8'h02);
    rd_reg(CB, 2, v);    chk("R7 tx under service", v, 8'h08);
    wr(CA, 1'b0, 8'h28);
    rd_reg(CB, 2, v);    chk("R7 tx clear re-raises rx", v, 8'h0C);
    wr(CA, 1'b1, 8'h03);
    wr(CA, 1'b0, 8'h38);
    rd_reg(CB, 2, v);    chk("R8 IUS passes to tx", v, 8'h08);
    rd(CA, 1'b1, v);     chk("R5 byte kept", v, 8'h31);
    wr(CA, 1'b0, 8'h38);
    rd_reg(CB, 2, v);    chk("R8 IUS clears tx", v, 8'h06);
    chk("R8 tx still pending irq", {7'd0, irq}, 8'h01);
    wr(CA, 1'b0, 8'h28);
    chk("R6 irq low", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_vector;
    logic [7:0] v; logic rej;
    wr_reg(CA, 9, 8'h10);
    rx_strobe(CA, 8'h41, rej);
    rd_reg(CB, 2, v);    chk("R9 A rx high", v, 8'h30);
    rd(CA, 1'b1, v);
    wr(CA, 1'b1, 8'h00);
    rd_reg(CB, 2, v);    chk("R9 A tx high", v, 8'h10);
    wr(CA, 1'b0, 8'h28);
    rd_reg(CB, 2, v);    chk("R9 none low from B", v, 8'h06);
    wr_reg(CB, 9, 8'h10);
    rd_reg(CB, 2, v);    chk("R9 none high", v, 8'h60);
    wr(CB, 1'b1, 8'h00);
    rd_reg(CB, 2, v);    chk("R9 B tx", v, 8'h00);
    wr(CB, 1'b0, 8'h28);
    wr_reg(CB, 3, 8'h01);
    rx_strobe(CB, 8'h51, rej);
    rd_reg(CB, 2, v);    chk("R9 B rx high", v, 8'h20);
    rx_strobe(CA, 8'h52, rej);
    rd_reg(CB, 2, v);    chk("R9 A outranks B", v, 8'h30);
    rd_reg(CA, 3, v);    chk("R10 both rx", v, 8'h24);
    rd(CA, 1'b1, v);
    rd(CB, 1'b1, v);     chk("R5 B byte", v, 8'h51);
    rd_reg(CB, 2, v);    chk("R9 none after both", v, 8'h60);
  endtask

  task automatic t_break;
    logic [7:0] v;
    @(negedge clk); brk_evt[1] = 1'b1;
    @(negedge clk); brk_evt[1] = 1'b0;
    rd(CB, 1'b0, v);     chk("R12 break status", v, 8'hC4);
    chk("R12 break irq", {7'd0, irq}, 8'h01);
    rd_reg(CA, 3, v);    chk("R10 B external", v, 8'h01);
    wr_reg(CB, 15, 8'h00);
    chk("R12 break masked", {7'd0, irq}, 8'h00);
    rd_reg(CA, 3, v);    chk("R10 external masked", v, 8'h00);
  endtask

  task automatic t_chan_reset;
    logic [7:0] v;
    wr_reg(CA, 12, 8'h5A);
    wr_reg(CB, 12, 8'h33);
    wr_reg(CA, 9, 8'h40);
    rd_reg(CB, 12, v);   chk("R13 B reset from A", v, 8'h00);
    rd(CB, 1'b0, v);     chk("R13 B status", v, 8'h44);
    rd_reg(CB, 2, v);    chk("R13 stat high cleared", v, 8'h06);
    rd_reg(CA, 12, v);   chk("R13 A kept", v, 8'h5A);
    wr_reg(CB, 12, 8'h33);
    wr_reg(CB, 9, 8'h80);
    rd_reg(CA, 12, v);   chk("R13 A reset from B", v, 8'h00);
    rd_reg(CB, 12, v);   chk("R13 B kept", v, 8'h33);
    wr_reg(CA, 12, 8'h5A);
    wr_reg(CA, 9, 8'hC0);
    rd_reg(CA, 12, v);   chk("R13 both A", v, 8'h00);
    rd_reg(CB, 12, v);   chk("R13 both B", v, 8'h00);
    @(negedge clk); brk_evt[1] = 1'b1;
    @(negedge clk); brk_evt[1] = 1'b0;
    chk("R1 break enable restored", {7'd0, irq}, 8'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_sel = 1'b0; host_we = 1'b0; host_addr = '0;
    host_wdata = '0; rx_valid = '0; rx_data = '0; brk_evt = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pointer();
    t_receive();
    t_irq();
    t_transmit();
    t_service();
    t_vector();
    t_break();
    t_chan_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule